// File: doc/BRIEF.md
# I2C Master Register Front End

This block sits between a 32-bit register bus and the bit-level engine of an I2C master. Software loads command words into a small transmit queue, takes received bytes from a receive queue, watches a status word of event flags and queue state, and programs interrupt enables, a self-clearing soft reset and the two SCL period counts. The engine pulls commands from the transmit queue, pushes received bytes into the receive queue and reports bus events as one-cycle pulses. A single level interrupt output tells software that an enabled condition is pending.

Register offsets: 0x00 is the queue port (a write pushes a transmit command, a read pops a received byte), 0x04 is status, 0x08 is control, 0x0C is the SCL high count and 0x10 is the SCL low count. Every other offset reads as zero. Status bits: 0 transfer-done, 1 arbitration-lost, 2 no-acknowledge, 3 data-request, 4 bus-active, 5 receive-empty, 6 transmit-empty, 7 receive-full, 8 transmit-full. Control bits: 0 arbitration-lost enable, 1 no-acknowledge enable, 2 data-request enable, 3 receive-full enable, 4 receive-data-available enable, 8 soft reset. A transmit command is the low 10 bits of the write data: bits 7:0 data, bit 8 request a START, bit 9 request a STOP.

Top module: `i2cm_csr`

## Requirements
- R1: After reset, status reads 0x060 (both queues empty, no flags), control, high count and low count read 0, the interrupt is low and no command is offered to the engine.
- R2: Words written to offset 0x00 are offered on `tx_cmd` in write order with `tx_avail` high; each `tx_pop` removes the head; with DEPTH=4, a fifth write while full is dropped and status bit 8 reads 1 while full.
- R3: Bytes pushed by `rx_push` are returned by reads of offset 0x00 in arrival order; a push into a full queue is dropped and status bit 7 reads 1 while full; a read while empty returns 0 and removes nothing.
- R4: Status bits 0 and 1 are set by `ev_done` and `ev_arb_lost` and stay set until software writes a 1 to that bit of offset 0x04; when a set pulse and a clearing write coincide, the bit stays set.
- R5: Status bit 4 is set by `ev_start` and cleared by `ev_stop`.
- R6: Status bit 2 is set by `ev_nack` and cleared by the next `ev_start`; status bit 3 reads 1 exactly while bit 4 is 1 and the transmit queue is empty.
- R7: `irq` is high exactly when at least one of arbitration-lost, no-acknowledge, data-request, receive-full and receive-not-empty is true with its control enable (bits 0 to 4) set.
- R8: Writing control bit 8 as 1 empties both queues, clears bus-active and no-acknowledge, drives `eng_abort`, and drops transmit writes; bit 8 reads 1 while `eng_busy` is high and reads 0 from the cycle after `eng_busy` is low.
- R9: Offsets 0x0C and 0x10 hold 16-bit counts that read back as written and drive `scl_high` and `scl_low`; reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (pops the receive queue at offset 0x00) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current offset |
| irq | output | 1 | Level interrupt |
| tx_cmd | output | 10 | Head transmit command |
| tx_avail | output | 1 | Transmit queue holds a command |
| tx_pop | input | 1 | Engine consumes the head command |
| rx_byte | input | 8 | Received byte from the engine |
| rx_push | input | 1 | Engine stores `rx_byte` |
| ev_start | input | 1 | Pulse: START seen on the bus |
| ev_stop | input | 1 | Pulse: STOP seen on the bus |
| ev_done | input | 1 | Pulse: transfer finished |
| ev_arb_lost | input | 1 | Pulse: arbitration lost |
| ev_nack | input | 1 | Pulse: slave did not acknowledge |
| eng_busy | input | 1 | Engine not yet idle |
| eng_abort | output | 1 | Soft reset in progress, engine must go idle |
| scl_high | output | 16 | SCL high count |
| scl_low | output | 16 | SCL low count |

## Verification
The queues are tried with in-order fills, overfills past the depth and reads from an empty queue, which separates ordering faults from full and empty pointer faults. Status flags are driven by lone pulses, by clearing writes and by a pulse landing on the same cycle as its clearing write, so sticky, write-one-to-clear and set-priority behaviour are told apart from one another. The interrupt is checked one enable at a time against its own source, and the soft reset is held by a busy engine and then released, so the flush and the self-clear timing are seen separately.

// File: rtl/i2cm_csr.sv
`timescale 1ns/1ps
module i2cm_csr #(
  parameter int DEPTH = 4,
  parameter int CW    = 10,
  parameter int TW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          irq,
  output logic [CW-1:0] tx_cmd,
  output logic          tx_avail,
  input  logic          tx_pop,
  input  logic [7:0]    rx_byte,
  input  logic          rx_push,
  input  logic          ev_start,
  input  logic          ev_stop,
  input  logic          ev_done,
  input  logic          ev_arb_lost,
  input  logic          ev_nack,
  input  logic          eng_busy,
  output logic          eng_abort,
  output logic [TW-1:0] scl_high,
  output logic [TW-1:0] scl_low
);
  localparam int PW = $clog2(DEPTH);

  logic [CW-1:0] txm [DEPTH];
  logic [7:0]    rxm [DEPTH];
  logic [PW:0]   tw, tr, rw, rr;
  logic          srst, done_f, arb_f, nack_f, active;
  logic [4:0]    en;

  wire sel_q   = bus_addr == 8'h00;
  wire sel_sts = bus_addr == 8'h04;
  wire sel_ctl = bus_addr == 8'h08;

  wire tx_empty = tw == tr;
  wire rx_empty = rw == rr;
  wire tx_full  = (tw[PW] != tr[PW]) && (tw[PW-1:0] == tr[PW-1:0]);
  wire rx_full  = (rw[PW] != rr[PW]) && (rw[PW-1:0] == rr[PW-1:0]);

  wire srst_req = bus_wr && sel_ctl && bus_wdata[8];
  wire flush    = srst || srst_req;
  wire tx_in    = bus_wr && sel_q && !tx_full && !flush;
  wire tx_out   = tx_pop && !tx_empty && !flush;
  wire rx_in    = rx_push && !rx_full && !flush;
  wire rx_out   = bus_rd && sel_q && !rx_empty && !flush;
  wire sts_wr   = bus_wr && sel_sts;
  wire drq      = active && tx_empty;

  wire [8:0] sts = {tx_full, rx_full, tx_empty, rx_empty, active, drq, nack_f, arb_f, done_f};

  assign tx_cmd    = txm[tr[PW-1:0]];
  assign tx_avail  = !tx_empty;
  assign eng_abort = srst;
  assign irq = (arb_f & en[0]) | (nack_f & en[1]) | (drq & en[2]) |
               (rx_full & en[3]) | (!rx_empty & en[4]);

  always_ff @(posedge clk) begin
    if (tx_in) txm[tw[PW-1:0]] <= bus_wdata[CW-1:0];
    if (rx_in) rxm[rw[PW-1:0]] <= rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {tw, tr, rw, rr} <= '0;
      {srst, done_f, arb_f, nack_f, active} <= '0;
      en <= '0;
      scl_high <= '0;
      scl_low  <= '0;
    end else begin
      if (flush) begin
        {tw, tr, rw, rr} <= '0;
      end else begin
        if (tx_in)  tw <= tw + 1'b1;
        if (tx_out) tr <= tr + 1'b1;
        if (rx_in)  rw <= rw + 1'b1;
        if (rx_out) rr <= rr + 1'b1;
      end
      if (srst_req) srst <= 1'b1;
      else if (srst && !eng_busy) srst <= 1'b0;
      done_f <= ev_done     | (done_f & !(sts_wr & bus_wdata[0]));
      arb_f  <= ev_arb_lost | (arb_f  & !(sts_wr & bus_wdata[1]));
      if (flush) active <= 1'b0;
      else if (ev_start) active <= 1'b1;
      else if (ev_stop) active <= 1'b0;
      if (flush || ev_start) nack_f <= 1'b0;
      else if (ev_nack) nack_f <= 1'b1;
      if (bus_wr && sel_ctl) en <= bus_wdata[4:0];
      if (bus_wr && bus_addr == 8'h0C) scl_high <= bus_wdata[TW-1:0];
      if (bus_wr && bus_addr == 8'h10) scl_low  <= bus_wdata[TW-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      8'h00: bus_rdata[7:0]    = rx_empty ? 8'h00 : rxm[rr[PW-1:0]];
      8'h04: bus_rdata[8:0]    = sts;
      8'h08: bus_rdata[8:0]    = {srst, 3'b000, en};
      8'h0C: bus_rdata[TW-1:0] = scl_high;
      8'h10: bus_rdata[TW-1:0] = scl_low;
      default: bus_rdata = '0;
    endcase
  end

  AST_SRST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    srst && eng_busy |=> srst); // R8
  AST_SRST_FLUSHED: assert property (@(posedge clk) disable iff (!rst_n)
    srst |-> tx_empty && rx_empty && !active); // R8
  AST_DONE_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> done_f); // R4
  AST_TX_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full && !tx_pop && !flush |=> tx_full); // R2
  AST_RX_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && sel_q && rx_empty && !flush |=> $stable(rr)); // R3
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    en == 5'd0 |-> !irq); // R7
  AST_ACTIVE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop && !ev_start |=> !active); // R5
endmodule

// File: tb/i2cm_csr_tb.sv
`timescale 1ns/1ps
module i2cm_csr_tb_top;
  logic clk = 0, rst_n = 0;
  logic [7:0] bus_addr = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic irq, tx_avail, tx_pop = 0, rx_push = 0, eng_abort;
  logic [9:0] tx_cmd;
  logic [7:0] rx_byte = 0;
  logic ev_start = 0, ev_stop = 0, ev_done = 0, ev_arb_lost = 0, ev_nack = 0, eng_busy = 0;
  logic [15:0] scl_high, scl_low;

  int n_chk = 0, n_bad = 0;
  logic [31:0] exp_q [$];
  string tag_q [$];
  logic mon_req = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  i2cm_csr dut_i (.clk, .rst_n, .bus_addr, .bus_wr, .bus_rd, .bus_wdata, .bus_rdata,
    .irq, .tx_cmd, .tx_avail, .tx_pop, .rx_byte, .rx_push, .ev_start, .ev_stop,
    .ev_done, .ev_arb_lost, .ev_nack, .eng_busy, .eng_abort, .scl_high, .scl_low);

  always @(negedge clk) begin
    #5;
    if (mon_req && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (bus_rdata !== e) begin
        n_bad++;
        $display("FAIL %s: read 0x%0h got 0x%0h expected 0x%0h", t, bus_addr, bus_rdata, e);
      end
    end
  end

  task automatic check(input string t, input logic [31:0] act, input logic [31:0] exp);
    #6;
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", t, act, exp);
    end
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_addr = a; bus_rd = 1;
    exp_q.push_back(e); tag_q.push_back(t); mon_req = 1;
    @(posedge clk); #1;
    bus_rd = 0; mon_req = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input int ev = 0);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    if (ev == 2) ev_arb_lost = 1;
    @(posedge clk); #1;
    bus_wr = 0; ev_arb_lost = 0;
  endtask

  task automatic pulse(input int k);
    @(negedge clk);
    case (k)
      1: ev_start = 1;
      2: ev_arb_lost = 1;
      3: ev_stop = 1;
      4: ev_done = 1;
      default: ev_nack = 1;
    endcase
    @(posedge clk); #1;
    {ev_start, ev_arb_lost, ev_stop, ev_done, ev_nack} = '0;
  endtask

  task automatic push_rx(input logic [7:0] b);
    @(negedge clk); rx_byte = b; rx_push = 1;
    @(posedge clk); #1; rx_push = 0;
  endtask

  task automatic pop_tx();
    @(negedge clk); tx_pop = 1;
    @(posedge clk); #1; tx_pop = 0;
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1
    rd_chk(8'h04, 32'h060, "R1 status");
    rd_chk(8'h08, 32'h0, "R1 control");
    rd_chk(8'h0C, 32'h0, "R1 high");
    check("R1 irq", irq, 0);
    check("R1 tx_avail", tx_avail, 0);
    // R9
    wr(8'h0C, 32'h3F);
    wr(8'h10, 32'h40);
    rd_chk(8'h0C, 32'h3F, "R9 high");
    rd_chk(8'h10, 32'h40, "R9 low");
    check("R9 scl_high port", scl_high, 16'h3F);
    check("R9 scl_low port", scl_low, 16'h40);
    rd_chk(8'h20, 32'h0, "R9 unmapped 0x20");
    rd_chk(8'hFC, 32'h0, "R9 unmapped 0xFC");
    // R2
    wr(8'h00, 32'h101); wr(8'h00, 32'h022); wr(8'h00, 32'h033); wr(8'h00, 32'h244);
    wr(8'h00, 32'h055);
    rd_chk(8'h04, 32'h120, "R2 tx full status");
    check("R2 avail", tx_avail, 1);
    check("R2 head0", tx_cmd, 10'h101);
    pop_tx(); check("R2 head1", tx_cmd, 10'h022);
    pop_tx(); check("R2 head2", tx_cmd, 10'h033);
    pop_tx(); check("R2 head3", tx_cmd, 10'h244);
    pop_tx(); check("R2 empty after overfill drop", tx_avail, 0);
    // R3
    rd_chk(8'h00, 32'h0, "R3 empty read");
    rd_chk(8'h00, 32'h0, "R3 empty read again");
    push_rx(8'hA1); push_rx(8'hB2);
    rd_chk(8'h00, 32'hA1, "R3 first byte");
    rd_chk(8'h00, 32'hB2, "R3 second byte");
    rd_chk(8'h00, 32'h0, "R3 drained");
    push_rx(8'h11); push_rx(8'h22); push_rx(8'h33); push_rx(8'h44); push_rx(8'h55);
    rd_chk(8'h04, 32'h0C0, "R3 rx full status");
    rd_chk(8'h00, 32'h11, "R3 full order 0");
    rd_chk(8'h00, 32'h22, "R3 full order 1");
    rd_chk(8'h00, 32'h33, "R3 full order 2");
    rd_chk(8'h00, 32'h44, "R3 full order 3");
    rd_chk(8'h04, 32'h060, "R3 overfill byte dropped");
    // R5 R6
    pulse(1);
    rd_chk(8'h04, 32'h078, "R5 active with R6 data request");
    pulse(5);
    rd_chk(8'h04, 32'h07C, "R6 nack set");
    wr(8'h00, 32'h0AA);
    rd_chk(8'h04, 32'h034, "R6 data request off with queued byte");
    pop_tx();
    pulse(3);
    rd_chk(8'h04, 32'h064, "R5 stop clears active, R6 nack kept");
    pulse(1);
    rd_chk(8'h04, 32'h078, "R6 start clears nack");
    pulse(3);
    rd_chk(8'h04, 32'h060, "R5 idle");
    // R4
    pulse(4);
    rd_chk(8'h04, 32'h061, "R4 done set");
    pulse(2);
    rd_chk(8'h04, 32'h063, "R4 arb set");
    wr(8'h04, 32'h1);
    rd_chk(8'h04, 32'h062, "R4 done cleared, arb kept");
    wr(8'h04, 32'h2, 2);
    rd_chk(8'h04, 32'h062, "R4 set wins over clear");
    wr(8'h04, 32'h2);
    rd_chk(8'h04, 32'h060, "R4 arb cleared");
    // R7
    wr(8'h08, 32'h01);
    check("R7 no source", irq, 0);
    pulse(2);
    check("R7 arb irq", irq, 1);
    wr(8'h04, 32'h2);
    check("R7 arb cleared irq", irq, 0);
    wr(8'h08, 32'h10);
    push_rx(8'h77);
    check("R7 rx avail irq", irq, 1);
    rd_chk(8'h00, 32'h77, "R7 rx avail byte");
    check("R7 rx drained irq", irq, 0);
    wr(8'h08, 32'h04);
    pulse(1);
    check("R7 data request irq", irq, 1);
    pulse(3);
    check("R7 data request gone", irq, 0);
    wr(8'h08, 32'h08);
    push_rx(8'h1); push_rx(8'h2); push_rx(8'h3);
    check("R7 rx not yet full", irq, 0);
    push_rx(8'h4);
    check("R7 rx full irq", irq, 1);
    wr(8'h08, 32'h00);
    check("R7 disabled", irq, 0);
    // R8
    eng_busy = 1;
    pulse(1);
    wr(8'h00, 32'h099);
    wr(8'h08, 32'h101);
    rd_chk(8'h08, 32'h101, "R8 reset bit held");
    check("R8 abort", eng_abort, 1);
    rd_chk(8'h04, 32'h060, "R8 flushed and idle");
    wr(8'h00, 32'h0CC);
    check("R8 tx write dropped", tx_avail, 0);
    rd_chk(8'h08, 32'h101, "R8 still busy");
    @(negedge clk); eng_busy = 0;
    @(posedge clk); #1;
    rd_chk(8'h08, 32'h001, "R8 self cleared");
    check("R8 abort released", eng_abort, 0);
    rd_chk(8'h04, 32'h060, "R8 status after reset");
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule